// File: doc/BRIEF.md
# Shared-Function Bidirectional Port Controller

An eight-pin bidirectional port whose pins are claimed, one by one, either by software or by on-chip functions. Software sees two registers on a small register bus: an output latch and a per-pin direction mask. Each pin can also be taken over by one of three things. The first is a serial transmit/receive unit on pins 0 and 1. The second is a synchronous serial unit on pins 2 to 5. The third is the external-bus control logic on pins 6 and 7. For every pin the block decides three things: whether the pad is driven, what value it drives, and what a read of the data register returns.

Pad levels enter through a two-flop synchronizer. The synchronized levels feed register readback and the receive-side signals of the peripherals. On pin 5, the block also turns the synchronized level into the select input and the mode-fault input of the synchronous serial unit. The serial units and the pad cells are outside this block and appear only as enable, request and value signals.

Top module: `pmux_port`

## Requirements
- R1: After reset the latch and direction registers are both 0x00 and every pad_oe_o bit is 0.
- R2: A write with reg_addr_i 0x8 loads the latch and a write with 0x9 loads the direction mask, each taking effect on the clock edge that samples reg_we_i. Reading 0x9 returns the mask. Any other address reads 0x00, and writes to it change neither register.
- R3: With no function claiming a pin, direction bit 1 drives the pad from its latch bit (pad_oe_o=1), and direction bit 0 leaves it undriven.
- R4: A data-register read returns, for an undriven pin, the pad level after two clock edges (one edge is not enough). For a driven pin it returns the value on pad_o.
- R5: A latch write made while a pin is an input is kept, and that value appears on the pad as soon as the pin's direction bit is set.
- R6: With mode_exp_i high, pin 7 drives bus_as_i and pin 6 drives bus_rw_i, both enabled whatever their direction bits say.
- R7: With spi_en_i high and spi_master_i low, pin 5 is undriven whatever direction bit 5 says, and spi_ss_o follows the synchronized pin 5 level.
- R8: With spi_en_i and spi_master_i high, direction bit 5 = 1 makes pin 5 a driven output from latch bit 5, and direction bit 5 = 0 makes it an input.
- R9: spi_mode_fault_o is high exactly when spi_en_i and spi_master_i are high, direction bit 5 is 0 and the synchronized pin 5 level is 0.
- R10: With spi_en_i high, a pin 2+k (k=0..2) whose spi_exp_out_i[k] is 0 is undriven whatever its direction bit says. spi_in_o[k] carries its synchronized level.
- R11: With spi_en_i high, a pin 2+k whose spi_exp_out_i[k] is 1 drives spi_out_i[k] only when its direction bit is 1, and is undriven otherwise.
- R12: With sci_rx_en_i high, pin 0 is undriven whatever direction bit 0 says. sci_rx_o always carries the synchronized pin 0 level.
- R13: With sci_tx_en_i high, pin 1 is driven with sci_tx_i whatever direction bit 1 says.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 4 | Register address |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| mode_exp_i | input | 1 | External-bus or test mode: pins 7/6 become bus control |
| bus_as_i | input | 1 | Address-strobe value for pin 7 |
| bus_rw_i | input | 1 | Read/write value for pin 6 |
| sci_rx_en_i | input | 1 | Serial receiver enabled, claims pin 0 |
| sci_tx_en_i | input | 1 | Serial transmitter enabled, claims pin 1 |
| sci_tx_i | input | 1 | Transmit value for pin 1 |
| sci_rx_o | output | 1 | Synchronized pin 0 level |
| spi_en_i | input | 1 | Synchronous serial unit enabled |
| spi_master_i | input | 1 | 1 = master, 0 = slave |
| spi_exp_out_i | input | 3 | Per pin 2..4: 1 = unit wants to drive it |
| spi_out_i | input | 3 | Values for pins 2..4 |
| spi_in_o | output | 3 | Synchronized levels of pins 2..4 |
| spi_ss_o | output | 1 | Synchronized pin 5 level (select input) |
| spi_mode_fault_o | output | 1 | Mode-fault indication to the unit |
| pad_i | input | 8 | Pad input levels |
| pad_o | output | 8 | Pad output values |
| pad_oe_o | output | 8 | Pad output enables |

## Verification
A corrupted direction bit or latch bit shows up on pad_oe_o or pad_o in the cycle after the write that should have set it. A read of register 0x9 or 0x8 exposes it at once. A wrong ownership decision shows on pad_oe_o in the same cycle that the enable or mode input changes. A synchronizer fault shows up in reg_rdata_o, sci_rx_o, spi_in_o, spi_ss_o and spi_mode_fault_o. A wrong stage count appears as a level that arrives one edge early or late, so the bench samples both after one edge and after two edges.

// File: rtl/pmux_pkg.sv
package pmux_pkg;
  localparam int PORT_W  = 8;
  localparam int ADDR_W  = 4;
  localparam int SPI_LO  = 2;
  localparam int SPI_W   = 3;
  localparam int SS_BIT  = 5;
  localparam int RX_BIT  = 0;
  localparam int TX_BIT  = 1;
  localparam int RW_BIT  = 6;
  localparam int AS_BIT  = 7;
  localparam logic [ADDR_W-1:0] DATA_OFS = 4'h8;
  localparam logic [ADDR_W-1:0] DIR_OFS  = 4'h9;

  typedef enum logic [2:0] {
    ROLE_GPIO,
    ROLE_SCI_RX,
    ROLE_SCI_TX,
    ROLE_SPI_DATA,
    ROLE_SPI_SEL,
    ROLE_BUS_RW,
    ROLE_BUS_AS
  } pin_role_e;

  function automatic pin_role_e role_of(int idx);
    if (idx == RX_BIT) return ROLE_SCI_RX;
    if (idx == TX_BIT) return ROLE_SCI_TX;
    if (idx >= SPI_LO && idx < SPI_LO + SPI_W) return ROLE_SPI_DATA;
    if (idx == SS_BIT) return ROLE_SPI_SEL;
    if (idx == RW_BIT) return ROLE_BUS_RW;
    if (idx == AS_BIT) return ROLE_BUS_AS;
    return ROLE_GPIO;
  endfunction
endpackage

// File: rtl/pmux_sync.sv
module pmux_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg1_q, stg2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg1_q <= '0;
      stg2_q <= '0;
    end else begin
      stg1_q <= d_i;
      stg2_q <= stg1_q;
    end
  end

  assign q_o = stg2_q;
endmodule

// File: rtl/pmux_regs.sv
module pmux_regs #(
  parameter int                 W        = 8,
  parameter int                 AW       = 4,
  parameter logic [AW-1:0]      DATA_OFS = 4'h8,
  parameter logic [AW-1:0]      DIR_OFS  = 4'h9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [W-1:0]  rd_view_i,
  output logic [W-1:0]  latch_o,
  output logic [W-1:0]  dir_o,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] latch_q, dir_q;
  logic         hit_data, hit_dir;

  assign hit_data = (addr_i == DATA_OFS);
  assign hit_dir  = (addr_i == DIR_OFS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else if (we_i) begin
      if (hit_data) latch_q <= wdata_i;
      if (hit_dir)  dir_q   <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_data)     rdata_o = rd_view_i;
    else if (hit_dir) rdata_o = dir_q;
  end

  assign latch_o = latch_q;
  assign dir_o   = dir_q;
endmodule

// File: rtl/pmux_resolve.sv
module pmux_resolve
  import pmux_pkg::*;
#(
  parameter int W = PORT_W
) (
  input  logic [W-1:0]     latch_i,
  input  logic [W-1:0]     dir_i,
  input  logic             mode_exp_i,
  input  logic             bus_as_i,
  input  logic             bus_rw_i,
  input  logic             sci_rx_en_i,
  input  logic             sci_tx_en_i,
  input  logic             sci_tx_i,
  input  logic             spi_en_i,
  input  logic             spi_master_i,
  input  logic [SPI_W-1:0] spi_exp_out_i,
  input  logic [SPI_W-1:0] spi_out_i,
  output logic [W-1:0]     oe_o,
  output logic [W-1:0]     out_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    localparam pin_role_e ROLE = role_of(i);
    if (ROLE == ROLE_SCI_RX) begin : g_rx
      assign oe_o[i]  = sci_rx_en_i ? 1'b0 : dir_i[i];
      assign out_o[i] = latch_i[i];
    end else if (ROLE == ROLE_SCI_TX) begin : g_tx
      assign oe_o[i]  = sci_tx_en_i | dir_i[i];
      assign out_o[i] = sci_tx_en_i ? sci_tx_i : latch_i[i];
    end else if (ROLE == ROLE_SPI_DATA) begin : g_spi
      // SPI-owned inputs are forced; SPI-owned outputs still need the dir bit
      logic want_out;
      assign want_out = spi_exp_out_i[i-SPI_LO];
      assign oe_o[i]  = spi_en_i ? (want_out & dir_i[i]) : dir_i[i];
      assign out_o[i] = (spi_en_i && want_out) ? spi_out_i[i-SPI_LO] : latch_i[i];
    end else if (ROLE == ROLE_SPI_SEL) begin : g_ss
      assign oe_o[i]  = spi_en_i ? (spi_master_i & dir_i[i]) : dir_i[i];
      assign out_o[i] = latch_i[i];
    end else if (ROLE == ROLE_BUS_RW) begin : g_rw
      assign oe_o[i]  = mode_exp_i | dir_i[i];
      assign out_o[i] = mode_exp_i ? bus_rw_i : latch_i[i];
    end else if (ROLE == ROLE_BUS_AS) begin : g_as
      assign oe_o[i]  = mode_exp_i | dir_i[i];
      assign out_o[i] = mode_exp_i ? bus_as_i : latch_i[i];
    end else begin : g_gpio
      assign oe_o[i]  = dir_i[i];
      assign out_o[i] = latch_i[i];
    end
  end
endmodule

// File: rtl/pmux_port.sv
module pmux_port
  import pmux_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [PORT_W-1:0] reg_wdata_i,
  output logic [PORT_W-1:0] reg_rdata_o,
  input  logic              mode_exp_i,
  input  logic              bus_as_i,
  input  logic              bus_rw_i,
  input  logic              sci_rx_en_i,
  input  logic              sci_tx_en_i,
  input  logic              sci_tx_i,
  output logic              sci_rx_o,
  input  logic              spi_en_i,
  input  logic              spi_master_i,
  input  logic [SPI_W-1:0]  spi_exp_out_i,
  input  logic [SPI_W-1:0]  spi_out_i,
  output logic [SPI_W-1:0]  spi_in_o,
  output logic              spi_ss_o,
  output logic              spi_mode_fault_o,
  input  logic [PORT_W-1:0] pad_i,
  output logic [PORT_W-1:0] pad_o,
  output logic [PORT_W-1:0] pad_oe_o
);
  logic [PORT_W-1:0] pin_sync, latch, dir, oe, drv, rd_view;

  pmux_sync #(.W(PORT_W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (pin_sync)
  );

  // driven pins read back the driver input, others the synchronized pad
  assign rd_view = (oe & drv) | (~oe & pin_sync);

  pmux_regs #(
    .W       (PORT_W),
    .AW      (ADDR_W),
    .DATA_OFS(DATA_OFS),
    .DIR_OFS (DIR_OFS)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (reg_addr_i),
    .we_i     (reg_we_i),
    .wdata_i  (reg_wdata_i),
    .rd_view_i(rd_view),
    .latch_o  (latch),
    .dir_o    (dir),
    .rdata_o  (reg_rdata_o)
  );

  pmux_resolve #(.W(PORT_W)) u_resolve (
    .latch_i      (latch),
    .dir_i        (dir),
    .mode_exp_i   (mode_exp_i),
    .bus_as_i     (bus_as_i),
    .bus_rw_i     (bus_rw_i),
    .sci_rx_en_i  (sci_rx_en_i),
    .sci_tx_en_i  (sci_tx_en_i),
    .sci_tx_i     (sci_tx_i),
    .spi_en_i     (spi_en_i),
    .spi_master_i (spi_master_i),
    .spi_exp_out_i(spi_exp_out_i),
    .spi_out_i    (spi_out_i),
    .oe_o         (oe),
    .out_o        (drv)
  );

  assign pad_oe_o         = oe;
  assign pad_o            = drv;
  assign sci_rx_o         = pin_sync[RX_BIT];
  assign spi_in_o         = pin_sync[SPI_LO +: SPI_W];
  assign spi_ss_o         = pin_sync[SS_BIT];
  assign spi_mode_fault_o = spi_en_i & spi_master_i & ~dir[SS_BIT] & ~pin_sync[SS_BIT];
endmodule

// File: rtl/pmux_port_chk.sv
module pmux_port_chk
  import pmux_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_exp_i,
  input logic              bus_as_i,
  input logic              bus_rw_i,
  input logic              sci_rx_en_i,
  input logic              sci_tx_en_i,
  input logic              sci_tx_i,
  input logic              spi_en_i,
  input logic              spi_master_i,
  input logic [SPI_W-1:0]  spi_exp_out_i,
  input logic              spi_mode_fault_o,
  input logic [PORT_W-1:0] pad_o,
  input logic [PORT_W-1:0] pad_oe_o
);
  AST_BUS_PINS_OWNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_exp_i |-> (pad_oe_o[AS_BIT] && pad_oe_o[RW_BIT] &&
                    pad_o[AS_BIT] == bus_as_i && pad_o[RW_BIT] == bus_rw_i)); // R6

  AST_SLAVE_SEL_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_en_i && !spi_master_i) |-> !pad_oe_o[SS_BIT]); // R7

  AST_MASTER_OUT_NO_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_en_i && spi_master_i && pad_oe_o[SS_BIT]) |-> !spi_mode_fault_o); // R8

  AST_FAULT_NEEDS_MASTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_mode_fault_o |-> (spi_en_i && spi_master_i && !pad_oe_o[SS_BIT])); // R9

  AST_SPI_IN_FORCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_en_i |-> ((pad_oe_o[SPI_LO +: SPI_W] & ~spi_exp_out_i) == '0)); // R10

  AST_SCI_RX_UNDRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sci_rx_en_i |-> !pad_oe_o[RX_BIT]); // R12

  AST_SCI_TX_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sci_tx_en_i |-> (pad_oe_o[TX_BIT] && pad_o[TX_BIT] == sci_tx_i)); // R13
endmodule

bind pmux_port pmux_port_chk chk_i (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .mode_exp_i      (mode_exp_i),
  .bus_as_i        (bus_as_i),
  .bus_rw_i        (bus_rw_i),
  .sci_rx_en_i     (sci_rx_en_i),
  .sci_tx_en_i     (sci_tx_en_i),
  .sci_tx_i        (sci_tx_i),
  .spi_en_i        (spi_en_i),
  .spi_master_i    (spi_master_i),
  .spi_exp_out_i   (spi_exp_out_i),
  .spi_mode_fault_o(spi_mode_fault_o),
  .pad_o           (pad_o),
  .pad_oe_o        (pad_oe_o)
);

// File: tb/pmux_port_tb.sv
module pmux_port_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] reg_addr_i = '0;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       mode_exp_i = 1'b0, bus_as_i = 1'b0, bus_rw_i = 1'b0;
  logic       sci_rx_en_i = 1'b0, sci_tx_en_i = 1'b0, sci_tx_i = 1'b0;
  logic       sci_rx_o;
  logic       spi_en_i = 1'b0, spi_master_i = 1'b0;
  logic [2:0] spi_exp_out_i = '0, spi_out_i = '0, spi_in_o;
  logic       spi_ss_o, spi_mode_fault_o;
  logic [7:0] pad_i = '0, pad_o, pad_oe_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk_i = ~clk_i;

  pmux_port dut_i (.*);

  task automatic check(string req, string what, logic [7:0] got, logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic edges(int n);
    for (int k = 0; k < n; k++) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    edges(1);
    reg_we_i = 1'b0;
    #1;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    pad_i = 8'hA5;
    rst_ni = 1'b0;
    edges(2);
    check("R1", "oe in reset", pad_oe_o, 8'h00);
    rst_ni = 1'b1;
    edges(3);
    check("R1", "oe after reset", pad_oe_o, 8'h00);
    rd(4'h9, d); check("R1", "dir reset", d, 8'h00);
    rd(4'h8, d); check("R1", "data reads pads", d, 8'hA5);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    wr(4'h9, 8'h5A);
    rd(4'h9, d); check("R2", "dir readback", d, 8'h5A);
    wr(4'h3, 8'hFF);
    rd(4'h3, d); check("R2", "unmapped read", d, 8'h00);
    rd(4'h9, d); check("R2", "dir after stray write", d, 8'h5A);
    wr(4'h9, 8'h00);
    rd(4'h8, d); check("R2", "latch after stray write", d, pad_i);
  endtask

  task automatic t_gpio;
    logic [7:0] d;
    pad_i = 8'h00;
    wr(4'h8, 8'h3C);
    wr(4'h9, 8'h0F);
    check("R3", "oe", pad_oe_o, 8'h0F);
    check("R3", "out", pad_o & pad_oe_o, 8'h0C);
    edges(2);
    rd(4'h8, d); check("R4", "mixed readback", d, 8'h0C);
    wr(4'h9, 8'h00);
    check("R3", "oe cleared", pad_oe_o, 8'h00);
  endtask

  task automatic t_sync;
    logic [7:0] d;
    pad_i = 8'h00;
    edges(3);
    pad_i = 8'hC3;
    edges(1);
    rd(4'h8, d); check("R4", "after one edge", d, 8'h00);
    edges(1);
    rd(4'h8, d); check("R4", "after two edges", d, 8'hC3);
  endtask

  task automatic t_retain;
    wr(4'h8, 8'h96);
    check("R5", "still undriven", pad_oe_o, 8'h00);
    wr(4'h9, 8'hFF);
    check("R5", "held value out", pad_o, 8'h96);
    wr(4'h9, 8'h00);
  endtask

  task automatic t_bus;
    logic [7:0] d;
    pad_i = 8'h00;
    wr(4'h8, 8'h00);
    mode_exp_i = 1'b1; bus_as_i = 1'b1; bus_rw_i = 1'b0;
    #1;
    check("R6", "bus oe", pad_oe_o, 8'hC0);
    check("R6", "bus values", pad_o & 8'hC0, 8'h80);
    edges(2);
    rd(4'h8, d); check("R6", "bus readback", d, 8'h80);
    bus_as_i = 1'b0; bus_rw_i = 1'b1;
    #1;
    check("R6", "bus values swapped", pad_o & 8'hC0, 8'h40);
    mode_exp_i = 1'b0;
    #1;
    check("R6", "released", pad_oe_o, 8'h00);
  endtask

  task automatic t_spi_slave;
    pad_i = 8'h00;
    spi_en_i = 1'b1; spi_master_i = 1'b0;
    wr(4'h9, 8'h20);
    check("R7", "ss undriven", pad_oe_o & 8'h20, 8'h00);
    pad_i = 8'h20;
    edges(2);
    check("R7", "ss follows", {7'd0, spi_ss_o}, 8'h01);
    check("R9", "no fault as slave", {7'd0, spi_mode_fault_o}, 8'h00);
    spi_en_i = 1'b0;
    wr(4'h9, 8'h00);
  endtask

  task automatic t_spi_master;
    pad_i = 8'h00;
    spi_en_i = 1'b1; spi_master_i = 1'b1;
    wr(4'h8, 8'h20);
    wr(4'h9, 8'h20);
    check("R8", "ss as output", pad_oe_o & 8'h20, 8'h20);
    check("R8", "ss latch value", pad_o & 8'h20, 8'h20);
    check("R9", "no fault when output", {7'd0, spi_mode_fault_o}, 8'h00);
    wr(4'h9, 8'h00);
    check("R8", "ss as input", pad_oe_o & 8'h20, 8'h00);
    check("R9", "fault on low", {7'd0, spi_mode_fault_o}, 8'h01);
    pad_i = 8'h20;
    edges(1);
    check("R9", "fault held one edge", {7'd0, spi_mode_fault_o}, 8'h01);
    edges(1);
    check("R9", "fault clears high", {7'd0, spi_mode_fault_o}, 8'h00);
    spi_en_i = 1'b0; spi_master_i = 1'b0;
    wr(4'h8, 8'h00);
  endtask

  task automatic t_spi_data;
    pad_i = 8'h00;
    wr(4'h9, 8'h1C);
    spi_en_i = 1'b1; spi_exp_out_i = 3'b110; spi_out_i = 3'b101;
    #1;
    check("R10", "pin2 forced input", pad_oe_o & 8'h1C, 8'h18);
    check("R11", "spi values", pad_o & 8'h18, 8'h10);
    spi_out_i = 3'b010;
    #1;
    check("R11", "spi values change", pad_o & 8'h18, 8'h08);
    wr(4'h9, 8'h00);
    check("R11", "no dir no drive", pad_oe_o, 8'h00);
    pad_i = 8'h14;
    edges(2);
    check("R10", "spi_in levels", {5'd0, spi_in_o}, 8'h05);
    spi_en_i = 1'b0; spi_exp_out_i = '0;
  endtask

  task automatic t_sci;
    pad_i = 8'h00;
    wr(4'h9, 8'h03);
    wr(4'h8, 8'h02);
    sci_rx_en_i = 1'b1; sci_tx_en_i = 1'b0;
    #1;
    check("R12", "rx undriven", pad_oe_o & 8'h03, 8'h02);
    pad_i = 8'h01;
    edges(2);
    check("R12", "rx level", {7'd0, sci_rx_o}, 8'h01);
    wr(4'h9, 8'h00);
    sci_tx_en_i = 1'b1; sci_tx_i = 1'b1;
    #1;
    check("R13", "tx driven", pad_oe_o & 8'h03, 8'h02);
    check("R13", "tx value", pad_o & 8'h02, 8'h02);
    sci_tx_i = 1'b0;
    #1;
    check("R13", "tx value low", pad_o & 8'h02, 8'h00);
    sci_rx_en_i = 1'b0; sci_tx_en_i = 1'b0;
  endtask

  initial begin
    t_reset;
    t_regs;
    t_gpio;
    t_sync;
    t_retain;
    t_bus;
    t_spi_slave;
    t_spi_master;
    t_spi_data;
    t_sci;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule